// File: doc/BRIEF.md
# Reference Tick and Start Event Selector

This block produces the common timing base for a set of acquisition and output engines: a stream of one-cycle reference ticks and a one-cycle start pulse. The tick stream comes either from an internal counter that divides the system clock (two rate settings, nominally 2.0 MHz and 1.5 MHz) or from edges on one of three external pins: two general sync pins, each with a selectable edge polarity, and a chain clock pin driven by an upstream unit.

No tick is emitted until a start event occurs. The start event is a software pulse, a selected edge on either sync pin, or an edge on a chain start pin. When the start event occurs, the internal divider is cleared. Every engine that counts ticks from `start_o` therefore begins in phase. The run continues until software issues a stop, which returns the block to its waiting state. The tick and start pulses are always repeated on chain outputs so that a downstream unit can select them as its reference and start sources.

All external pins pass through a two-flop synchroniser and an edge detector. At the default parameters, the system clock is assumed to be 12 MHz (divide by 6 gives 2.0 MHz, divide by 8 gives 1.5 MHz).

Top module: `ref_start_sel`

## Requirements
- R1: After reset, `waiting_o`=1, `running_o`=0, and `tick_o`, `start_o`, `chain_clk_o`, `chain_start_o` are all 0.
- R2: While `waiting_o`=1, `tick_o` stays 0 whatever activity appears on the selected reference source.
- R3: With `start_sel_i`=0 (software), a `sw_start_i` pulse sampled while waiting makes `start_o` high for exactly one cycle, in the next cycle. `running_o` rises and `waiting_o` falls in that same cycle.
- R4: With `ref_sel_i`=0 (internal), `int_rate_i`=0 divides by DIV_HI and `int_rate_i`=1 divides by DIV_LO. The first tick comes DIV cycles after the `start_o` cycle, and later ticks come every DIV cycles.
- R5: With `start_sel_i`=1 or 2 (sync pin 1 or 2), `start_edge_i`=0 selects rising edges and 1 selects falling edges. `start_o` goes high on the third clock edge that samples the new pin level, and the opposite edge does not start the block.
- R6: With `ref_sel_i`=1 or 2, each selected edge on that sync pin (`ref_edge_i`=0 rising, 1 falling) gives one `tick_o` pulse on the third clock edge that samples the new level, but only while running. The opposite edge gives no tick.
- R7: `ref_sel_i`=3 takes ticks from `chain_clk_i` edges, using the `ref_edge_i` polarity. `start_sel_i`=3 takes the start from `chain_start_i` edges, using the `start_edge_i` polarity.
- R8: Once running, further start events are ignored. Only `sw_stop_i` ends the run: in the next cycle `running_o`=0 and `waiting_o`=1, and no tick follows.
- R9: `chain_clk_o` equals `tick_o` and `chain_start_o` equals `start_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sel_i | input | 2 | Reference source: 0 internal, 1 sync pin 1, 2 sync pin 2, 3 chain clock |
| ref_edge_i | input | 1 | Reference edge polarity for external sources: 0 rising, 1 falling |
| int_rate_i | input | 1 | Internal rate: 0 divide by DIV_HI, 1 divide by DIV_LO |
| start_sel_i | input | 2 | Start source: 0 software, 1 sync pin 1, 2 sync pin 2, 3 chain start |
| start_edge_i | input | 1 | Start edge polarity for external sources: 0 rising, 1 falling |
| sync1_i | input | 1 | Asynchronous sync pin 1 |
| sync2_i | input | 1 | Asynchronous sync pin 2 |
| chain_clk_i | input | 1 | Reference from an upstream unit |
| chain_start_i | input | 1 | Start from an upstream unit |
| sw_start_i | input | 1 | Software start pulse, synchronous |
| sw_stop_i | input | 1 | Software stop pulse, synchronous |
| tick_o | output | 1 | One-cycle reference tick |
| start_o | output | 1 | One-cycle start pulse |
| waiting_o | output | 1 | Waiting for a start event |
| running_o | output | 1 | Tick stream active |
| chain_clk_o | output | 1 | Repeated tick for a downstream unit |
| chain_start_o | output | 1 | Repeated start for a downstream unit |

## Verification
The tick stream is measured under six source settings: both internal rates, both edge polarities on sync pin 1, sync pin 2, and the chain clock. An asymmetric square wave drives the external cases. The internal cases test the divisor selection and the phase of the first tick after start. The external cases show that the source multiplexer picks the intended pin. Directed tests apply single edges of each polarity to the start and reference paths. A correct result depends on both the chosen edge and the synchroniser latency, so these tests separate polarity errors from latency errors. They also show that start events are ignored during a run and that only the software stop ends it.

// File: rtl/ref_start_pkg.sv
package ref_start_pkg;
  typedef enum logic [1:0] {
    REF_INT   = 2'd0,
    REF_SYNC1 = 2'd1,
    REF_SYNC2 = 2'd2,
    REF_CHAIN = 2'd3
  } ref_src_e;

  typedef enum logic [1:0] {
    ST_SW    = 2'd0,
    ST_SYNC1 = 2'd1,
    ST_SYNC2 = 2'd2,
    ST_CHAIN = 2'd3
  } start_src_e;

  // index of each external pin in the synchroniser bank
  localparam int unsigned PIN_SYNC1  = 0;
  localparam int unsigned PIN_SYNC2  = 1;
  localparam int unsigned PIN_CCLK   = 2;
  localparam int unsigned PIN_CSTART = 3;
  localparam int unsigned NUM_PINS   = 4;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic [CW-1:0] div_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  // >= keeps the count bounded if the divisor shrinks mid-run
  assign wrap  = (cnt_q >= div_i - 1'b1);
  assign hit_o = en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_start_sel.sv
module ref_start_sel
  import ref_start_pkg::*;
#(
  parameter int unsigned DIV_HI      = 6,
  parameter int unsigned DIV_LO      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ref_sel_i,
  input  logic       ref_edge_i,
  input  logic       int_rate_i,
  input  logic [1:0] start_sel_i,
  input  logic       start_edge_i,
  input  logic       sync1_i,
  input  logic       sync2_i,
  input  logic       chain_clk_i,
  input  logic       chain_start_i,
  input  logic       sw_start_i,
  input  logic       sw_stop_i,
  output logic       tick_o,
  output logic       start_o,
  output logic       waiting_o,
  output logic       running_o,
  output logic       chain_clk_o,
  output logic       chain_start_o
);
  localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int unsigned CW      = $clog2(DIV_MAX + 1);

  logic [NUM_PINS-1:0] pins, rise, fall;
  assign pins[PIN_SYNC1]  = sync1_i;
  assign pins[PIN_SYNC2]  = sync2_i;
  assign pins[PIN_CCLK]   = chain_clk_i;
  assign pins[PIN_CSTART] = chain_start_i;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins[g]),
      .rise_o(rise[g]),
      .fall_o(fall[g])
    );
  end

  logic [NUM_PINS-1:0] ref_ev, st_ev;
  assign ref_ev = ref_edge_i   ? fall : rise;
  assign st_ev  = start_edge_i ? fall : rise;

  ref_src_e   ref_src;
  start_src_e st_src;
  assign ref_src = ref_src_e'(ref_sel_i);
  assign st_src  = start_src_e'(start_sel_i);

  logic start_evt, ext_tick;
  always_comb begin
    unique case (st_src)
      ST_SW:    start_evt = sw_start_i;
      ST_SYNC1: start_evt = st_ev[PIN_SYNC1];
      ST_SYNC2: start_evt = st_ev[PIN_SYNC2];
      default:  start_evt = st_ev[PIN_CSTART];
    endcase
    unique case (ref_src)
      REF_SYNC1: ext_tick = ref_ev[PIN_SYNC1];
      REF_SYNC2: ext_tick = ref_ev[PIN_SYNC2];
      REF_CHAIN: ext_tick = ref_ev[PIN_CCLK];
      default:   ext_tick = 1'b0;
    endcase
  end

  logic run_q, run_nxt, start_now;
  assign start_now = ~run_q & start_evt;
  assign run_nxt   = start_now | (run_q & ~sw_stop_i);

  logic [CW-1:0] div_sel;
  logic          int_hit;
  assign div_sel = int_rate_i ? CW'(DIV_LO) : CW'(DIV_HI);

  ref_divider #(.CW(CW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_now),
    .en_i   (run_q),
    .div_i  (div_sel),
    .hit_o  (int_hit)
  );

  logic tick_q, start_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      tick_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      run_q   <= run_nxt;
      start_q <= start_now;
      // gated by run_nxt so a stop cycle emits no tick
      tick_q  <= run_q & run_nxt & ((ref_src == REF_INT) ? int_hit : ext_tick);
    end
  end

  assign tick_o        = tick_q;
  assign start_o       = start_q;
  assign running_o     = run_q;
  assign waiting_o     = ~run_q;
  assign chain_clk_o   = tick_q;
  assign chain_start_o = start_q;
endmodule

// File: rtl/ref_start_sel_chk.sv
module ref_start_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] ref_sel_i,
  input logic       sw_stop_i,
  input logic       tick_o,
  input logic       start_o,
  input logic       waiting_o,
  input logic       running_o
);
  p_no_tick_waiting_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_o |-> !tick_o);

  p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_run_begins_with_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> start_o);

  p_start_from_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(waiting_o));

  p_int_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ref_sel_i == 2'd0 && $stable(ref_sel_i)) |=> !tick_o);

  p_stop_only_sw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> $past(sw_stop_i));

  p_state_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({waiting_o, running_o}));
endmodule

bind ref_start_sel ref_start_sel_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_sel_i(ref_sel_i),
  .sw_stop_i(sw_stop_i),
  .tick_o   (tick_o),
  .start_o  (start_o),
  .waiting_o(waiting_o),
  .running_o(running_o)
);

// File: tb/ref_start_sel_tb.sv
`timescale 1ns/1ps
module ref_start_sel_tb;
  localparam int DIV_HI = 6;
  localparam int DIV_LO = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] ref_sel = 2'd0, start_sel = 2'd0;
  logic ref_edge = 1'b0, start_edge = 1'b0, int_rate = 1'b0;
  logic man_s1 = 1'b0, man_s2 = 1'b0, man_cclk = 1'b0, man_cst = 1'b0;
  logic sw_start = 1'b0, sw_stop = 1'b0;
  logic gen_en = 1'b0, wave = 1'b0;
  logic tick, start, waiting, running, cclk_o, cst_o;
  logic s1, s2, cclk;
  int   checks = 0, errors = 0, ph = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  assign s1   = gen_en ? wave : man_s1;
  assign s2   = gen_en ? wave : man_s2;
  assign cclk = gen_en ? wave : man_cclk;

  // asymmetric wave: high 3, low 7, period 10 cycles
  always @(negedge clk) begin
    ph   <= (ph + 1) % 10;
    wave <= ((ph + 1) % 10) < 3;
  end

  ref_start_sel #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ref_sel_i(ref_sel), .ref_edge_i(ref_edge), .int_rate_i(int_rate),
    .start_sel_i(start_sel), .start_edge_i(start_edge),
    .sync1_i(s1), .sync2_i(s2), .chain_clk_i(cclk), .chain_start_i(man_cst),
    .sw_start_i(sw_start), .sw_stop_i(sw_stop),
    .tick_o(tick), .start_o(start), .waiting_o(waiting), .running_o(running),
    .chain_clk_o(cclk_o), .chain_start_o(cst_o)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic       edge_f;
    logic       rate;
    logic [7:0] gap;
    logic       check_first;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 1'b0, 8'(DIV_HI), 1'b1},
    '{2'd0, 1'b0, 1'b1, 8'(DIV_LO), 1'b1},
    '{2'd1, 1'b0, 1'b0, 8'd10,      1'b0},
    '{2'd1, 1'b1, 1'b0, 8'd10,      1'b0},
    '{2'd2, 1'b0, 1'b0, 8'd10,      1'b0},
    '{2'd3, 1'b1, 1'b0, 8'd10,      1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int lim, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tick && n < lim);
  endtask

  task automatic sw_start_pulse();
    sw_start = 1'b1; step(); sw_start = 1'b0;
  endtask

  task automatic sw_stop_pulse();
    sw_stop = 1'b1; step(); sw_stop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, cnt;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(waiting == 1 && running == 0, "R1 state", {waiting, running}, 2);
    check(tick == 0 && start == 0 && cclk_o == 0 && cst_o == 0, "R1 outputs",
          {tick, start, cclk_o, cst_o}, 0);

    // R2 no ticks while waiting, internal and external source
    cnt = 0;
    repeat (20) begin step(); cnt += tick; end
    ref_sel = 2'd1; gen_en = 1'b1;
    repeat (30) begin step(); cnt += tick; end
    check(cnt == 0 && waiting == 1, "R2 ticks while waiting", cnt, 0);
    gen_en = 1'b0; ref_sel = 2'd0;

    // vector table: R3 start, R4 divider, R6/R7 external references
    foreach (VECS[i]) begin
      ref_sel = VECS[i].sel; ref_edge = VECS[i].edge_f; int_rate = VECS[i].rate;
      gen_en = (VECS[i].sel != 2'd0);
      repeat (12) step();
      sw_start_pulse();
      check(start == 1 && running == 1 && waiting == 0, "R3 sw start", start, 1);
      check(cst_o == start, "R9 chain start", cst_o, start);
      step();
      check(start == 0, "R3 single pulse", start, 0);
      wait_tick(40, n);
      if (VECS[i].check_first)
        check(n + 1 == int'(VECS[i].gap), "R4 first tick", n + 1, VECS[i].gap);
      else
        check(n < 40, "R7 ext tick arrives", n, 1);
      check(cclk_o == tick, "R9 chain clk", cclk_o, tick);
      wait_tick(40, n);
      check(n == int'(VECS[i].gap), (VECS[i].sel == 2'd3) ? "R7 chain gap" :
            (VECS[i].sel == 2'd0) ? "R4 int gap" : "R6 sync gap", n, VECS[i].gap);
      sw_stop_pulse();
      check(running == 0 && waiting == 1, "R8 stop", running, 0);
      gen_en = 1'b0;
    end

    // R8 no ticks after stop
    ref_sel = 2'd0;
    cnt = 0;
    repeat (20) begin step(); cnt += tick; end
    check(cnt == 0, "R8 silent after stop", cnt, 0);

    // R5 rising start on sync pin 1, latency three edges
    start_sel = 2'd1; start_edge = 1'b0; man_s1 = 1'b1;
    step(); check(start == 0, "R5 early 1", start, 0);
    step(); check(start == 0, "R5 early 2", start, 0);
    step(); check(start == 1 && running == 1, "R5 rise start", start, 1);

    // R8 start events ignored while running
    man_s1 = 1'b0; repeat (4) step();
    man_s1 = 1'b1;
    cnt = 0;
    repeat (6) begin step(); cnt += start; end
    check(cnt == 0 && running == 1, "R8 restart ignored", cnt, 0);
    sw_stop_pulse();
    check(waiting == 1, "R8 stop wait", waiting, 1);

    // R5 falling start on sync pin 2: rising edge must not start
    start_sel = 2'd2; start_edge = 1'b1; man_s2 = 1'b1;
    cnt = 0;
    repeat (6) begin step(); cnt += start; end
    check(cnt == 0 && waiting == 1, "R5 wrong edge", cnt, 0);
    man_s2 = 1'b0;
    step(); step();
    check(start == 0, "R5 fall early", start, 0);
    step();
    check(start == 1, "R5 fall start", start, 1);
    sw_stop_pulse();

    // R7 chain start rising
    start_sel = 2'd3; start_edge = 1'b0; man_cst = 1'b1;
    step(); step();
    check(start == 0, "R7 chain early", start, 0);
    step();
    check(start == 1 && cst_o == 1, "R7 chain start", start, 1);
    sw_stop_pulse();

    // R6 falling reference on sync pin 1 via single edges
    start_sel = 2'd0; ref_sel = 2'd1; ref_edge = 1'b1; man_s1 = 1'b1;
    repeat (4) step();
    sw_start_pulse();
    man_s1 = 1'b0;
    step(); step();
    check(tick == 0, "R6 tick early", tick, 0);
    step();
    check(tick == 1 && cclk_o == 1, "R6 fall tick", tick, 1);
    man_s1 = 1'b1;
    cnt = 0;
    repeat (6) begin step(); cnt += tick; end
    check(cnt == 0, "R6 wrong edge no tick", cnt, 0);
    sw_stop_pulse();

    finish_run();
  end
endmodule